// File: doc/BRIEF.md
# Fully Associative Translation Buffer Slot Manager

This block keeps a fully associative buffer of translation entries, each a 64-bit tag paired with a 64-bit data word, beside a bank of sixteen 64-bit control registers. A simple register-access bus carries each request as an operation code, an address and write data. The response comes back exactly one cycle later. The operations fill the buffer, look inside it and reach the registers. The buffer can be filled by an automatic insert, which chooses its own victim slot, or by a write to a named slot. Both take the new tag from the tag-staging register (register 6) and the new data word from the write data.

A tag search returns the tag of the first valid entry that holds the searched value, or zero when no entry holds it. Two indexed read operations return the data word or the tag of any slot. A fault-logging input lets the surrounding translation logic record a fault status and a fault address in registers 3 and 4. A bus write to the status register with its low bit clear wipes both of those registers.

The victim search and the tag search each scan all entries inside the request cycle. No operation stalls.

Top module: `tlb_slot_manager`

## Requirements
- R1: After reset, rsp_valid is low, every slot's data word and tag read as 0 (so every entry is invalid), and every register reads 0.
- R2: A request with req_valid high gets rsp_valid high on the next cycle only. rsp_rdata is 0 whenever rsp_valid is low, and it is 0 for the write-type operations and for the no-op. The op codes are: 0 register write, 1 register read, 2 insert, 3 indexed write, 4 tag search, 5 slot data read, 6 slot tag read, 7 no-op.
- R3: An insert writes tag = register 6 and data = req_wdata into the lowest-indexed invalid slot. A slot is invalid when bit 63 of its data word is 0.
- R4: When no slot is invalid, an insert writes the lowest-indexed slot whose lock bit (data bit 6) is 0.
- R5: When every slot is valid and locked, an insert changes no slot.
- R6: An indexed write stores tag = register 6 and data = req_wdata in slot req_addr[8:3], whatever that slot held before.
- R7: A tag search with search value req_wdata returns the tag of the lowest valid slot whose tag equals req_wdata. It returns 0 when no valid slot matches. A slot that holds the tag but is invalid does not match.
- R8: Register reads and writes select register req_addr[6:3]. Bus writes to registers 0 and 4 have no effect. Bus writes to the other registers, except register 3, store req_wdata.
- R9: A bus write to register 3 with req_wdata[0] = 1 stores req_wdata. With req_wdata[0] = 0, it clears both register 3 and register 4.
- R10: When flog_en is high, register 3 takes flog_status and register 4 takes flog_addr. In the same cycle this takes priority over a bus write to either register.
- R11: A slot data read returns the data word, and a slot tag read returns the tag, of slot req_addr[8:3].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_addr | input | 9 | Slot number in [8:3], register number in [6:3] |
| req_wdata | input | 64 | Write data or search value |
| flog_en | input | 1 | Fault-log strobe |
| flog_status | input | 64 | Fault status to record |
| flog_addr | input | 64 | Fault address to record |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Response data |

## Verification
The bench fills the buffer completely with interleaved locked and unlocked entries, then reads back every slot. An encoder that picked the highest candidate instead of the lowest, or that ignored validity, would put entries in the wrong slots. It opens holes at non-adjacent slots to confirm that an insert takes the lowest hole. It then removes all holes so the insert must fall back to the first unlocked slot, and finally fills the buffer with locked entries. A design that evicted a locked entry would corrupt one slot in the final full read-back. It searches for a tag held only by an invalidated slot, which a design that skipped the valid check would return. It sweeps all sixteen registers and the clearing rules of the status register. A design that decoded the wrong address bits, stored writes to registers 0 or 4, or failed to clear the fault address would read back wrong values.

// File: rtl/tlb_slot_manager.sv
module tlb_slot_manager #(
  parameter int ENTRIES   = 64,
  parameter int DW        = 64,
  parameter int NREGS     = 16,
  parameter int ADDR_W    = 9,
  parameter int VALID_BIT = 63,
  parameter int LOCK_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              flog_en,
  input  logic [DW-1:0]     flog_status,
  input  logic [DW-1:0]     flog_addr,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int RIDX_W = $clog2(NREGS);
  localparam int REG_FSR  = 3;
  localparam int REG_FAR  = 4;
  localparam int REG_TAG  = 6;
  localparam logic [2:0] OP_RWR = 3'd0, OP_RRD = 3'd1, OP_INS = 3'd2, OP_IWR = 3'd3,
                         OP_SRCH = 3'd4, OP_DRD = 3'd5, OP_TRD = 3'd6;

  logic [DW-1:0] tag_q [ENTRIES];
  logic [DW-1:0] dat_q [ENTRIES];
  logic [DW-1:0] reg_q [NREGS];

  logic [ENTRIES-1:0] valid_v, unlock_v, hit_v;
  logic [IDX_W-1:0]   slot_idx;
  logic [RIDX_W-1:0]  reg_idx;
  logic               unused_addr_bits;

  assign slot_idx = req_addr[3 +: IDX_W];
  assign reg_idx  = req_addr[3 +: RIDX_W];
  assign unused_addr_bits = ^req_addr[2:0];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vec
    assign valid_v[g]  = dat_q[g][VALID_BIT];
    assign unlock_v[g] = ~dat_q[g][LOCK_BIT];
    assign hit_v[g]    = dat_q[g][VALID_BIT] && (tag_q[g] == req_wdata);
  end

  function automatic logic [IDX_W:0] pick_first(input logic [ENTRIES-1:0] v);
    pick_first = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (v[i]) pick_first = {1'b1, IDX_W'(i)};
  endfunction

  logic [IDX_W:0] free_pick, unlk_pick, hit_pick;
  assign free_pick = pick_first(~valid_v);
  assign unlk_pick = pick_first(unlock_v);
  assign hit_pick  = pick_first(hit_v);

  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = slot_idx;
    if (req_valid && req_op == OP_IWR) begin
      wr_en = 1'b1;
    end else if (req_valid && req_op == OP_INS) begin
      if (free_pick[IDX_W]) begin
        wr_en  = 1'b1;
        wr_idx = free_pick[IDX_W-1:0];
      end else if (unlk_pick[IDX_W]) begin
        wr_en  = 1'b1;
        wr_idx = unlk_pick[IDX_W-1:0];
      end
    end
  end

  logic [DW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (req_valid) begin
      case (req_op)
        OP_RRD:  rd_next = reg_q[reg_idx];
        OP_SRCH: rd_next = hit_pick[IDX_W] ? tag_q[hit_pick[IDX_W-1:0]] : '0;
        OP_DRD:  rd_next = dat_q[slot_idx];
        OP_TRD:  rd_next = tag_q[slot_idx];
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else if (wr_en) begin
      tag_q[wr_idx] <= reg_q[REG_TAG];
      dat_q[wr_idx] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) reg_q[i] <= '0;
    end else begin
      if (req_valid && req_op == OP_RWR) begin
        if (reg_idx == RIDX_W'(REG_FSR)) begin
          if (req_wdata[0]) begin
            reg_q[REG_FSR] <= req_wdata;
          end else begin
            reg_q[REG_FSR] <= '0;
            reg_q[REG_FAR] <= '0;
          end
        end else if (reg_idx != '0 && reg_idx != RIDX_W'(REG_FAR)) begin
          reg_q[reg_idx] <= req_wdata;
        end
      end
      if (flog_en) begin
        reg_q[REG_FSR] <= flog_status;
        reg_q[REG_FAR] <= flog_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd_next;
    end
  end
endmodule

// File: rtl/tlb_slot_manager_chk.sv
module tlb_slot_manager_chk #(
  parameter int ENTRIES = 64,
  parameter int DW      = 64,
  parameter int ADDR_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DW-1:0]     req_wdata,
  input logic              flog_en,
  input logic              rsp_valid,
  input logic [DW-1:0]     rsp_rdata,
  input logic [DW-1:0]     fsr_q,
  input logic [DW-1:0]     far_q,
  input logic [ENTRIES-1:0] valid_v,
  input logic [ENTRIES-1:0] unlock_v
);
  logic bus_rwr, bus_rrd, bus_ins, bus_srch;
  assign bus_rwr  = req_valid && req_op == 3'd0;
  assign bus_rrd  = req_valid && req_op == 3'd1;
  assign bus_ins  = req_valid && req_op == 3'd2;
  assign bus_srch = req_valid && req_op == 3'd4;

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> rsp_rdata == '0); // R2
  AST_REG0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rrd && req_addr[6:3] == 4'd0) |=> rsp_rdata == '0); // R8
  AST_FAR_BUS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rwr && req_addr[6:3] == 4'd4 && !flog_en) |=> $stable(far_q)); // R8
  AST_FSR_CLEARS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rwr && req_addr[6:3] == 4'd3 && !req_wdata[0] && !flog_en) |=> (fsr_q == '0 && far_q == '0)); // R9
  AST_SEARCH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_srch |=> (rsp_rdata == '0 || rsp_rdata == $past(req_wdata))); // R7
  AST_FULL_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ins && (&valid_v) && !(|unlock_v)) |=> ($stable(valid_v) && $stable(unlock_v))); // R5
  AST_INSERT_FILLS_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ins && !(&valid_v) && req_wdata[63]) |=> $countones(valid_v) == $countones($past(valid_v)) + 1); // R3
endmodule

bind tlb_slot_manager tlb_slot_manager_chk #(.ENTRIES(ENTRIES), .DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
  .req_wdata(req_wdata), .flog_en(flog_en), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .fsr_q(reg_q[3]), .far_q(reg_q[4]), .valid_v(valid_v), .unlock_v(unlock_v)
);

// File: tb/tlb_slot_manager_bench.sv
module tlb_slot_manager_bench;
  localparam int N = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd7;
  logic [8:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic flog_en = 1'b0;
  logic [63:0] flog_status = '0, flog_addr = '0;
  logic rsp_valid;
  logic [63:0] rsp_rdata;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [63:0] e_tag [N];
  logic [63:0] e_dat [N];
  logic [63:0] e_reg [16];
  logic [63:0] rd;

  always #2.5 clk = ~clk;

  tlb_slot_manager u_tlb_slot_manager (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .flog_en(flog_en), .flog_status(flog_status), .flog_addr(flog_addr),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] o, input logic [8:0] a, input logic [63:0] wd,
                    input string req, output logic [63:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_op = o; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_op = 3'd7;
    chk({req, " rsp_valid"}, {63'd0, rsp_valid}, 64'd1);
    r = rsp_rdata;
  endtask

  task automatic set_tag(input logic [63:0] t);
    op(3'd0, 9'(6 << 3), t, "R8", rd);
    e_reg[6] = t;
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < N; i++) begin
      op(3'd5, 9'(i << 3), 64'h0, "R11", rd);
      chk({req, " data"}, rd, e_dat[i]);
      op(3'd6, 9'(i << 3), 64'h0, "R11", rd);
      chk({req, " tag"}, rd, e_tag[i]);
    end
  endtask

  function automatic logic [63:0] dpat(input int i, input bit lock);
    return 64'h8000_0000_0000_0000 | (64'(i) << 12) | 64'h0BAD_0000 | (lock ? 64'h40 : 64'h0);
  endfunction

  function automatic logic [63:0] tpat(input int i);
    return 64'h5A00_0000_0000_0000 | (64'(i) * 64'h1_0001) | 64'h100;
  endfunction

  task automatic insert(input logic [63:0] t, input logic [63:0] d, input string req);
    int v;
    set_tag(t);
    v = -1;
    for (int i = N - 1; i >= 0; i--) if (!e_dat[i][63]) v = i;
    if (v < 0) for (int i = N - 1; i >= 0; i--) if (!e_dat[i][6]) v = i;
    op(3'd2, 9'h0, d, req, rd);
    chk({req, " insert rdata"}, rd, 64'h0);
    if (v >= 0) begin e_tag[v] = t; e_dat[v] = d; end
  endtask

  task automatic iwrite(input int s, input logic [63:0] t, input logic [63:0] d);
    set_tag(t);
    op(3'd3, 9'(s << 3), d, "R6", rd);
    e_tag[s] = t; e_dat[s] = d;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin e_tag[i] = '0; e_dat[i] = '0; end
    for (int i = 0; i < 16; i++) e_reg[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid idle", {63'd0, rsp_valid}, 64'd0);
    chk("R2 idle rdata", rsp_rdata, 64'd0);
    sweep("R1 reset slots");
    for (int r = 0; r < 16; r++) begin
      op(3'd1, 9'(r << 3), 64'h0, "R1", rd);
      chk("R1 reset reg", rd, 64'h0);
    end

    // R2: single-cycle response and no-op
    op(3'd7, 9'h0, 64'hFFFF, "R2", rd);
    chk("R2 noop rdata", rd, 64'h0);
    @(negedge clk);
    chk("R2 rsp drops", {63'd0, rsp_valid}, 64'd0);

    // R3: fill all slots by insert, even slots locked
    for (int i = 0; i < N; i++) insert(tpat(i), dpat(i, (i % 2) == 0), "R3");
    sweep("R3 fill");

    // R6/R3: open holes at 40 then 10, insert takes the lowest
    iwrite(40, 64'h77, 64'h0000_0000_0000_1111);
    iwrite(10, 64'h78, 64'h0000_0000_0000_2222);
    insert(64'hAAAA_0001, 64'h8000_0000_0000_AA00, "R3");
    chk("R3 lowest hole", e_tag[10], 64'hAAAA_0001);
    insert(64'hAAAA_0002, 64'h8000_0000_0000_AB00, "R3");
    sweep("R3 R6 holes");

    // R4: no holes, first unlocked slot (slot 1)
    insert(64'hBBBB_0001, 64'h8000_0000_0000_BB40, "R4");
    chk("R4 slot1 model", e_tag[1], 64'hBBBB_0001);
    sweep("R4 unlocked victim");

    // R5: lock every slot, insert is dropped
    for (int i = 0; i < N; i++) iwrite(i, tpat(i) ^ 64'hF0, dpat(i, 1'b1));
    insert(64'hCCCC_0001, 64'h8000_0000_0000_CC00, "R5");
    sweep("R5 full locked");

    // R7: searches
    for (int i = 0; i < N; i += 9) begin
      op(3'd4, 9'h0, e_tag[i], "R7", rd);
      chk("R7 hit", rd, e_tag[i]);
    end
    op(3'd4, 9'h0, 64'hDEAD_BEEF, "R7", rd);
    chk("R7 miss", rd, 64'h0);
    iwrite(20, 64'h1234_5678, 64'h0000_0000_0000_0040);
    op(3'd4, 9'h0, 64'h1234_5678, "R7", rd);
    chk("R7 invalid no match", rd, 64'h0);

    // R8/R9: register sweep
    for (int r = 0; r < 16; r++) begin
      logic [63:0] p;
      p = 64'hC0DE_0000_0000_0001 | (64'(r) << 8);
      op(3'd0, 9'(r << 3), p, "R8", rd);
      chk("R8 write rdata", rd, 64'h0);
      if (r != 0 && r != 4) e_reg[r] = p;
    end
    for (int r = 0; r < 16; r++) begin
      op(3'd1, 9'(r << 3), 64'h0, "R8", rd);
      chk("R8 R9 reg readback", rd, e_reg[r]);
    end

    // R10: fault log, then R9 clear rules
    @(negedge clk);
    flog_en = 1'b1; flog_status = 64'h5555_0002; flog_addr = 64'h0000_7000_1230;
    @(negedge clk);
    flog_en = 1'b0;
    op(3'd1, 9'(3 << 3), 64'h0, "R10", rd);
    chk("R10 status", rd, 64'h5555_0002);
    op(3'd1, 9'(4 << 3), 64'h0, "R10", rd);
    chk("R10 addr", rd, 64'h0000_7000_1230);
    op(3'd0, 9'(3 << 3), 64'h9001, "R9", rd);
    op(3'd1, 9'(3 << 3), 64'h0, "R9", rd);
    chk("R9 set stores", rd, 64'h9001);
    op(3'd1, 9'(4 << 3), 64'h0, "R9", rd);
    chk("R9 set keeps addr", rd, 64'h0000_7000_1230);
    op(3'd0, 9'(3 << 3), 64'h9000, "R9", rd);
    op(3'd1, 9'(3 << 3), 64'h0, "R9", rd);
    chk("R9 clear status", rd, 64'h0);
    op(3'd1, 9'(4 << 3), 64'h0, "R9", rd);
    chk("R9 clear addr", rd, 64'h0);
    @(negedge clk);
    flog_en = 1'b1; flog_status = 64'h0E; flog_addr = 64'hFA;
    req_valid = 1'b1; req_op = 3'd0; req_addr = 9'(3 << 3); req_wdata = 64'h0;
    @(negedge clk);
    flog_en = 1'b0; req_valid = 1'b0; req_op = 3'd7;
    op(3'd1, 9'(3 << 3), 64'h0, "R10", rd);
    chk("R10 log wins status", rd, 64'h0E);
    op(3'd1, 9'(4 << 3), 64'h0, "R10", rd);
    chk("R10 log wins addr", rd, 64'hFA);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule